// File: doc/BRIEF.md
# Edge-Triggered Interrupt Status Register

This block gathers seven event signals from a network controller's queue and link logic into one 16-bit status word that the host can read. Each status bit latches when its event input changes, not while the input stays at a level, and it stays set until the host writes a one to that bit. Reading the word has no side effects. A second word at its own address holds one enable bit for each status bit. A single registered interrupt line goes high while any status bit is set together with its enable bit.

Six of the events count on a 0-to-1 change of their input. The link event counts on a change in either direction of the link-up input. Both process-stopped bits come out of reset already set. The event inputs share the register clock. The edge stage holds a PRIME state for the first cycle after reset: in that cycle it only captures the input levels, so an input that is already high when reset ends does not produce a false event. After that it moves to RUN (transition PRIME->RUN, taken unconditionally) and stays there. The interrupt output comes from a two-state machine, IDLE and ACTIVE. It moves IDLE->ACTIVE when an enabled status bit is pending and ACTIVE->IDLE when none is pending.

Top module: `evt_irq_status`

## Requirements
- R1: After reset the status word reads 0x0300, so bits 9 and 8 are set and every other bit is clear. The enable word reads 0x0000 and irq_o is low.
- R2: The status bits sit at these positions: link change 15, transmit done 14, receive frame ready 13, receive overrun 11, transmit process stopped 9, receive process stopped 8, receive error frame 7. All other positions read 0 and cannot be set. The valid-bit mask is 0xEB80.
- R3: Each of tx_done_i, rx_frame_i, rx_ovr_i, tx_stop_i, rx_stop_i and rx_err_i sets its bit in the cycle after a 0-to-1 change. If the input stays high after the bit is cleared, the bit does not set again. A 1-to-0 change sets nothing.
- R4: link_up_i sets bit 15 in the cycle after it changes in either direction.
- R5: A set bit stays set over any number of cycles and reads. Reading the status address (offset 0) clears nothing.
- R6: A write to the status address clears each valid bit written as 1. Bits written as 0 keep their value.
- R7: If an event edge and a clearing write for the same bit fall in the same cycle, the bit ends up set.
- R8: The enable word sits at offset 2 and uses the same bit positions. A write loads it, masked to 0xEB80, so reserved positions always read 0.
- R9: irq_o is registered. It is high in the cycle after (status AND enable) is nonzero, and low in the cycle after that value becomes zero.
- R10: In the first cycle after reset no event is detected, whatever the input levels are. Inputs that are high while reset is active do not set any bit.
- R11: Every address other than offsets 0 and 2 reads 0x0000. A write to such an address changes neither word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for the addressed word (combinational) |
| link_up_i | input | 1 | Link status level |
| tx_done_i | input | 1 | Frame transmitted level |
| rx_frame_i | input | 1 | Receive frame ready level |
| rx_ovr_i | input | 1 | Receive overrun level |
| tx_stop_i | input | 1 | Transmit process stopped level |
| rx_stop_i | input | 1 | Receive process stopped level |
| rx_err_i | input | 1 | Receive error frame level |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its default parameters: a 4-bit address, the status word at offset 0 and the enable word at offset 2. With only sixteen addresses, the bench can write and read every unmapped offset and confirm that none of them reaches either word. A model in the bench, based on the 0xEB80 valid mask and the bit positions, follows every cycle of a directed walk over each source and each edge direction. It then follows a long pseudo-random run that mixes events, clearing writes and enable writes. In every cycle it compares both words and the interrupt line.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int unsigned REG_W   = 16;
    localparam int unsigned NUM_SRC = 7;

    // Source index -> status bit position (index 0 lowest position)
    localparam int unsigned SRC_POS [NUM_SRC] = '{7, 8, 9, 11, 13, 14, 15};

    // Sources that count both edges (only link status)
    localparam logic [NUM_SRC-1:0] SRC_BOTH_EDGES = 7'b100_0000;
    // Sources whose status bit comes out of reset set (both process-stopped)
    localparam logic [NUM_SRC-1:0] SRC_RESET_ONE  = 7'b000_0110;

    typedef enum logic {EDGE_PRIME, EDGE_RUN}  edge_state_e;
    typedef enum logic {IRQ_IDLE,  IRQ_ACTIVE} irq_state_e;

    function automatic logic [REG_W-1:0] scatter(input logic [NUM_SRC-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            r[SRC_POS[i]] = v[i];
        end
        return r;
    endfunction

    localparam logic [REG_W-1:0] VALID_MASK = scatter({NUM_SRC{1'b1}});
    localparam logic [REG_W-1:0] RESET_VAL  = scatter(SRC_RESET_ONE);

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import irq_stat_pkg::*;
#(
    parameter int unsigned    N    = NUM_SRC,
    parameter logic [N-1:0]   BOTH = SRC_BOTH_EDGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] pulse_o
);

    edge_state_e  state_q, state_d;
    logic [N-1:0] prev_q;
    logic [N-1:0] edge_w;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDGE_PRIME;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_PRIME: state_d = EDGE_RUN;
            EDGE_RUN:   state_d = EDGE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        if (BOTH[g]) begin : g_any
            assign edge_w[g] = level_i[g] ^ prev_q[g];
        end else begin : g_rise
            assign edge_w[g] = level_i[g] & ~prev_q[g];
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            EDGE_PRIME: pulse_o = '0;
            EDGE_RUN:   pulse_o = edge_w;
        endcase
    end

endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
    import irq_stat_pkg::*;
#(
    parameter int unsigned    W    = REG_W,
    parameter logic [W-1:0]   KEEP = VALID_MASK,
    parameter logic [W-1:0]   INIT = RESET_VAL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= INIT[g] & KEEP[g];
            else
                bit_q <= KEEP[g] & (set_i[g] | (bit_q & ~clr_i[g]));
        end
        assign q_o[g] = bit_q;
    end

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending_i)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!pending_i) state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_IDLE:   irq_o = 1'b0;
            IRQ_ACTIVE: irq_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
    import irq_stat_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 4,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 'd0,
    parameter logic [ADDR_W-1:0]  MASK_ADDR = 'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              link_up_i,
    input  logic              tx_done_i,
    input  logic              rx_frame_i,
    input  logic              rx_ovr_i,
    input  logic              tx_stop_i,
    input  logic              rx_stop_i,
    input  logic              rx_err_i,
    output logic              irq_o
);

    logic [NUM_SRC-1:0] src_lvl;
    logic [NUM_SRC-1:0] src_pulse;
    logic [REG_W-1:0]   set_vec;
    logic [REG_W-1:0]   clr_vec;
    logic [REG_W-1:0]   stat_q;
    logic [REG_W-1:0]   mask_q;
    logic               hit_stat;
    logic               hit_mask;
    logic               pending;

    // Source order follows ascending status bit position
    assign src_lvl = {link_up_i, tx_done_i, rx_frame_i, rx_ovr_i,
                      tx_stop_i, rx_stop_i, rx_err_i};

    irq_edge_detect #(
        .N    (NUM_SRC),
        .BOTH (SRC_BOTH_EDGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (src_lvl),
        .pulse_o (src_pulse)
    );

    assign set_vec  = scatter(src_pulse);
    assign hit_stat = (addr_i == STAT_ADDR);
    assign hit_mask = (addr_i == MASK_ADDR);
    assign clr_vec  = (wr_en_i && hit_stat) ? (wr_data_i & VALID_MASK) : '0;

    irq_sticky_bank #(
        .W    (REG_W),
        .KEEP (VALID_MASK),
        .INIT (RESET_VAL)
    ) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (stat_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q <= '0;
        else if (wr_en_i && hit_mask) mask_q <= wr_data_i & VALID_MASK;
    end

    assign pending = |(stat_q & mask_q);

    irq_out_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_o     (irq_o)
    );

    always_comb begin
        if (hit_stat)      rd_data_o = stat_q;
        else if (hit_mask) rd_data_o = mask_q;
        else               rd_data_o = '0;
    end

endmodule

// File: rtl/evt_irq_status_chk.sv
module evt_irq_status_chk
    import irq_stat_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'd0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic [REG_W-1:0]  stat_q,
    input logic [REG_W-1:0]  mask_q,
    input logic [REG_W-1:0]  set_vec,
    input logic              irq_o
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~VALID_MASK) == '0);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == STAT_ADDR) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == STAT_ADDR && set_vec == '0)
        |=> (stat_q == ($past(stat_q) & ~$past(wr_data_i))));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

    p_mask_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~VALID_MASK) == '0);

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & mask_q) != '0) |=> irq_o);

    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & mask_q) == '0) |=> !irq_o);

endmodule

bind evt_irq_status evt_irq_status_chk #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .set_vec   (set_vec),
    .irq_o     (irq_o)
);

// File: tb/evt_irq_status_tb.sv
module evt_irq_status_tb;

    localparam logic [3:0]  STAT  = 4'd0;
    localparam logic [3:0]  MASK  = 4'd2;
    localparam logic [15:0] VALID = 16'hEB80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic [6:0]  ev = '0;   // index: 0 rx_err .. 6 link

    int          pos [7] = '{7, 8, 9, 11, 13, 14, 15};
    logic [15:0] st_m, en_m;
    logic        irq_m, armed_m;
    logic [6:0]  prev_m;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    evt_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_data_o(rd_data),
        .link_up_i(ev[6]), .tx_done_i(ev[5]), .rx_frame_i(ev[4]),
        .rx_ovr_i(ev[3]), .tx_stop_i(ev[2]), .rx_stop_i(ev[1]),
        .rx_err_i(ev[0]), .irq_o(irq)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    // One clock: model updates from the requirements, then back to negedge
    task automatic tick();
        logic [15:0] setv, clrv;
        logic        irq_n;
        @(posedge clk);
        irq_n = |(st_m & en_m);
        setv = '0;
        if (armed_m) begin
            for (int i = 0; i < 6; i++) setv[pos[i]] = ev[i] & ~prev_m[i];
            setv[15] = ev[6] ^ prev_m[6];
        end
        clrv = (wr_en && addr == STAT) ? (wr_data & VALID) : 16'h0;
        if (wr_en && addr == MASK) en_m = wr_data & VALID;
        st_m    = (st_m & ~clrv) | setv;
        prev_m  = ev;
        armed_m = 1'b1;
        irq_m   = irq_n;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic verify(string tag);
        wr_en = 1'b0;
        addr = STAT; #1; check(tag, rd_data, st_m);
        addr = MASK; #1; check(tag, rd_data, en_m);
        check(tag, {15'b0, irq}, {15'b0, irq_m});
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        addr = a; wr_en = 1'b1; wr_data = d;
    endtask

    initial begin
        logic [15:0] lfsr;
        // R10: sources high during reset
        ev = 7'b110_0000;
        st_m = 16'h0300; en_m = '0; irq_m = 1'b0; armed_m = 1'b0; prev_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        verify("R1");
        tick(); verify("R10");
        tick(); verify("R10");

        wr(STAT, 16'hFFFF); tick(); verify("R6");

        // R3 / R2: each rising-edge source
        for (int i = 0; i < 6; i++) begin
            ev[i] = 1'b1; tick(); verify("R2");
            verify("R5"); tick(); verify("R5");
            wr(STAT, 16'h0001 << pos[i]); tick(); verify("R3");
            tick(); verify("R3");
            ev[i] = 1'b0; tick(); verify("R3");
        end
        // R4: link both directions
        ev[6] = 1'b0; tick(); verify("R4");
        wr(STAT, 16'h8000); tick(); verify("R4");
        ev[6] = 1'b1; tick(); verify("R4");
        // R6: writing zero keeps bits
        wr(STAT, 16'h0000); tick(); verify("R6");
        wr(STAT, 16'h7FFF); tick(); verify("R6");
        // R7: edge and clear together
        ev[0] = 1'b1; wr(STAT, 16'hFFFF); tick(); verify("R7");
        ev[0] = 1'b0;
        // R8 / R9
        wr(MASK, 16'hFFFF); tick(); verify("R8");
        tick(); verify("R9");
        wr(STAT, 16'hFFFF); tick(); verify("R9");
        tick(); verify("R9");
        ev[3] = 1'b1; tick(); verify("R9");
        tick(); verify("R9");
        wr(MASK, 16'h0000); tick(); verify("R9");
        tick(); verify("R9");
        wr(MASK, 16'h1234); tick(); verify("R8");
        // R11: unmapped addresses
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 2) continue;
            wr(4'(a), 16'hFFFF); tick();
            addr = 4'(a); #1; check("R11", rd_data, 16'h0000);
            verify("R11");
        end
        // Mixed pseudo-random run
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) ev = lfsr[13:7];
            if (lfsr[5:3] == 3'd1) wr(STAT, {lfsr[7:0], lfsr[15:8]});
            else if (lfsr[5:3] == 3'd2) wr(MASK, lfsr);
            tick(); verify("R3 R4 R6 R7 R9 mixed");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule